// File: doc/BRIEF.md
# Command-Response Buffer Register Controller

This block is the control-register front end of a trusted-module command-response buffer interface. A host reaches it over a simple memory-mapped bus with byte-granular accesses of one to four bytes. From that bus the block keeps the locality grant, the idle state and the start state. When the host asks for a command to run under the rules below, the block issues a one-cycle request pulse to the command engine. The engine answers with a one-cycle completion pulse that carries an error flag, and the block then clears its start state and latches any fatal error. The command engine and the data buffer memory are outside this block.

The address is split in two. Bits [11:0] select a register inside a 4 KiB page, and every page shows the same registers. Bits [15:12] give the locality the access belongs to. Only locality 0 can ever hold the grant, so a start request is taken only from page 0, and only while the grant is held.

Register offsets within a page (bit positions are given in the requirements):
0x000 locality state (read), 0x004 locality control (write), 0x008 locality status (read), 0x010 interface identity (read), 0x020 control request (write), 0x024 control status (read), 0x028 cancel (write, reads 0), 0x02C start (read/write).

Top module: `crb_regctl`

## Requirements
- R1: After reset, control status reads 0x2 (bit 1 idle = 1, bit 0 fatal = 0). Locality status reads 0 and start reads 0. Locality state reads 0x80 (bit 7 register-valid = 1, bit 1 assigned = 0, bits [4:2] active locality = 0), with bit 0 as given by R8. Interface identity reads 0x00025811: type 1 in [3:0], version 1 in [7:4], locality-0-only (bit 8 = 0), fast idle (bit 9 = 0), transfer-size code 0b11 in [12:11], no FIFO (bit 13 = 0), buffer interface supported (bit 14 = 1), selector 1 in [18:17], revision 0 in [31:24].
- R2: Writing exactly 1 to control request clears the idle bit, and writing exactly 2 sets it. Any other value leaves control status unchanged.
- R3: Writing exactly 1 to locality control sets granted (locality status bit 0), clears been-seized (locality status bit 1) and sets assigned (locality state bit 1). Writing exactly 2 clears assigned and granted. Any other value, including 8 (reset-establishment), has no effect.
- R4: A start write is accepted when three conditions hold: the value is exactly 1, the start bit (start register bit 0) is clear, and address bits [15:12] equal the active locality (0 while assigned, 0xFF while not assigned). When it is accepted, the start bit reads 1 and `issue_o` is high for exactly one cycle, the cycle after the write.
- R5: A start write that breaks any condition of R4 is ignored. This covers no locality assigned, a page other than 0, a value other than 1, and a start already pending. It produces no pulse and leaves the start bit unchanged.
- R6: Writing exactly 1 to cancel pulses `cancel_o` for one cycle, the cycle after the write, and only if the start bit is set. Otherwise the write has no effect.
- R7: A `done_i` pulse clears the start bit. If `done_err_i` is high in that cycle, control status bit 0 (fatal) is set, and it stays set until reset.
- R8: Locality state bit 0 reads as the inverse of `established_i`, sampled in the cycle the read is taken.
- R9: Reads return the register selected by the address with bits [1:0] cleared, shifted right by 8 times address bits [1:0], and masked to `bus_size`+1 bytes. Writes act only at the exact register offset, with the data masked to `bus_size`+1 bytes.
- R10: Reads of undefined offsets return 0. Writes to read-only or undefined offsets change nothing that can be read back.
- R11: When a start write meets `done_i` in the same cycle, the write is judged against the start bit as it stood before that cycle. If a start was pending, the write is rejected and the start bit ends clear.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_sel | input | 1 | Access valid this cycle |
| bus_wr | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 16 | Byte address; [15:12] locality, [11:0] offset |
| bus_size | input | 2 | Access size in bytes minus one |
| bus_wdata | input | 32 | Write data, little-endian |
| bus_rdata | output | 32 | Read data, valid when bus_rvalid |
| bus_rvalid | output | 1 | Read data valid, the cycle after the read |
| established_i | input | 1 | Established flag from the trusted module |
| issue_o | output | 1 | One-cycle command-issue pulse |
| cancel_o | output | 1 | One-cycle cancel pulse |
| done_i | input | 1 | One-cycle completion pulse |
| done_err_i | input | 1 | Completion reported an error, qualifies done_i |

## Verification
A host start write and the engine's completion pulse can land in the same cycle, and so can a cancel write and a completion. The bench provokes the first collision by driving a start write at page 0 together with `done_i` while a command is pending. It judges the result by three facts: no extra issue pulse follows, the start register then reads 0, and a later clean start is still accepted. The fatal bit is read back after a clean completion that follows an error, to show that it stays set.

// File: rtl/crb_pkg.sv
package crb_pkg;

   localparam int OFS_W = 12;

   localparam logic [OFS_W-1:0] OFS_LSTATE = 12'h000;
   localparam logic [OFS_W-1:0] OFS_LCTRL  = 12'h004;
   localparam logic [OFS_W-1:0] OFS_LSTS   = 12'h008;
   localparam logic [OFS_W-1:0] OFS_IDENT  = 12'h010;
   localparam logic [OFS_W-1:0] OFS_CREQ   = 12'h020;
   localparam logic [OFS_W-1:0] OFS_CSTS   = 12'h024;
   localparam logic [OFS_W-1:0] OFS_CANCEL = 12'h028;
   localparam logic [OFS_W-1:0] OFS_START  = 12'h02C;

   // locality state fields
   localparam int LS_EST     = 0;
   localparam int LS_ASSIGN  = 1;
   localparam int LS_ACT_LSB = 2;
   localparam int LS_ACT_W   = 3;
   localparam int LS_VALID   = 7;

   // locality status fields
   localparam int LT_GRANT = 0;
   localparam int LT_SEIZE = 1;

   // control status fields
   localparam int CS_FATAL = 0;
   localparam int CS_IDLE  = 1;

   // identity fields
   localparam int ID_TYPE_LSB = 0;
   localparam int ID_VER_LSB  = 4;
   localparam int ID_CAPLOC   = 8;
   localparam int ID_IDLEBYP  = 9;
   localparam int ID_XFER_LSB = 11;
   localparam int ID_FIFO     = 13;
   localparam int ID_BUFIF    = 14;
   localparam int ID_SEL_LSB  = 17;
   localparam int ID_REV_LSB  = 24;

   // command codes written by the host
   localparam int CODE_LOC_TAKE  = 1;
   localparam int CODE_LOC_DROP  = 2;
   localparam int CODE_REQ_READY = 1;
   localparam int CODE_REQ_IDLE  = 2;
   localparam int CODE_GO        = 1;

   typedef struct packed {
      logic lctrl;
      logic creq;
      logic cancel;
      logic start;
   } crb_whit_t;

endpackage

// File: rtl/crb_bus_dec.sv
module crb_bus_dec
   import crb_pkg::*;
#(
   parameter int ADDR_W  = 16,
   parameter int DATA_W  = 32,
   parameter int LOC_LSB = 12,
   parameter int LOC_W   = 4,
   localparam int BYTES  = DATA_W / 8,
   localparam int SZ_W   = $clog2(BYTES)
) (
   input  logic              sel,
   input  logic              wr,
   input  logic [ADDR_W-1:0] addr,
   input  logic [SZ_W-1:0]   size,
   input  logic [DATA_W-1:0] wdata,
   output crb_whit_t         whit,
   output logic [DATA_W-1:0] wval,
   output logic [DATA_W-1:0] lane_mask,
   output logic [LOC_W-1:0]  page_loc,
   output logic              rd_en
);

   logic [OFS_W-1:0] ofs;
   logic             wr_en;

   assign ofs      = addr[OFS_W-1:0];
   assign page_loc = addr[LOC_LSB +: LOC_W];
   assign wr_en    = sel & wr;
   assign rd_en    = sel & ~wr;

   always_comb begin
      for (int i = 0; i < BYTES; i++)
         lane_mask[8*i +: 8] = (i <= int'(size)) ? 8'hFF : 8'h00;
   end

   assign wval = wdata & lane_mask;

   always_comb begin
      whit        = '0;
      whit.lctrl  = wr_en && (ofs == OFS_LCTRL);
      whit.creq   = wr_en && (ofs == OFS_CREQ);
      whit.cancel = wr_en && (ofs == OFS_CANCEL);
      whit.start  = wr_en && (ofs == OFS_START);
   end

endmodule

// File: rtl/crb_loc_ctl.sv
module crb_loc_ctl
   import crb_pkg::*;
#(
   parameter int DATA_W = 32
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              hit,
   input  logic [DATA_W-1:0] wval,
   output logic              assigned,
   output logic              granted,
   output logic              seized
);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         assigned <= 1'b0;
         granted  <= 1'b0;
         seized   <= 1'b0;
      end else if (hit) begin
         if (wval == DATA_W'(CODE_LOC_TAKE)) begin
            assigned <= 1'b1;
            granted  <= 1'b1;
            seized   <= 1'b0;
         end else if (wval == DATA_W'(CODE_LOC_DROP)) begin
            assigned <= 1'b0;
            granted  <= 1'b0;
         end
      end
   end

endmodule

// File: rtl/crb_cmd_ctl.sv
module crb_cmd_ctl
   import crb_pkg::*;
#(
   parameter int DATA_W = 32,
   parameter int LOC_W  = 4,
   parameter int AL_W   = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  crb_whit_t         whit,
   input  logic [DATA_W-1:0] wval,
   input  logic [LOC_W-1:0]  page_loc,
   input  logic [AL_W-1:0]   active_loc,
   input  logic              done_i,
   input  logic              done_err_i,
   output logic              idle_q,
   output logic              fatal_q,
   output logic              busy_q,
   output logic              issue_q,
   output logic              cancel_q
);

   logic start_ok;
   logic cancel_ok;

   assign start_ok  = whit.start && (wval == DATA_W'(CODE_GO)) && !busy_q &&
                      (AL_W'(page_loc) == active_loc);
   assign cancel_ok = whit.cancel && (wval == DATA_W'(CODE_GO)) && busy_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         idle_q   <= 1'b1;
         fatal_q  <= 1'b0;
         busy_q   <= 1'b0;
         issue_q  <= 1'b0;
         cancel_q <= 1'b0;
      end else begin
         issue_q  <= start_ok;
         cancel_q <= cancel_ok;
         if (start_ok)
            busy_q <= 1'b1;
         else if (done_i)
            busy_q <= 1'b0;
         if (done_i && done_err_i)
            fatal_q <= 1'b1;
         if (whit.creq) begin
            if (wval == DATA_W'(CODE_REQ_READY))
               idle_q <= 1'b0;
            else if (wval == DATA_W'(CODE_REQ_IDLE))
               idle_q <= 1'b1;
         end
      end
   end

endmodule

// File: rtl/crb_rd_path.sv
module crb_rd_path
   import crb_pkg::*;
#(
   parameter int DATA_W = 32,
   parameter bit RD_REG = 1'b1,
   localparam int BYTES = DATA_W / 8,
   localparam int BO_W  = $clog2(BYTES)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              rd_en,
   input  logic [OFS_W-1:0]  ofs,
   input  logic [DATA_W-1:0] lane_mask,
   input  logic [DATA_W-1:0] w_lstate,
   input  logic [DATA_W-1:0] w_lsts,
   input  logic [DATA_W-1:0] w_ident,
   input  logic [DATA_W-1:0] w_csts,
   input  logic [DATA_W-1:0] w_start,
   output logic [DATA_W-1:0] rdata,
   output logic              rvalid
);

   logic [OFS_W-1:0]  aligned;
   logic [BO_W-1:0]   boff;
   logic [DATA_W-1:0] word;
   logic [DATA_W-1:0] shaped;

   assign aligned = {ofs[OFS_W-1:BO_W], {BO_W{1'b0}}};
   assign boff    = ofs[BO_W-1:0];

   always_comb begin
      unique case (aligned)
         OFS_LSTATE: word = w_lstate;
         OFS_LSTS:   word = w_lsts;
         OFS_IDENT:  word = w_ident;
         OFS_CSTS:   word = w_csts;
         OFS_START:  word = w_start;
         default:    word = '0;
      endcase
   end

   assign shaped = (word >> {boff, 3'b000}) & lane_mask;

   generate
      if (RD_REG) begin : g_reg
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               rdata  <= '0;
               rvalid <= 1'b0;
            end else begin
               rvalid <= rd_en;
               if (rd_en)
                  rdata <= shaped;
            end
         end
      end else begin : g_comb
         assign rdata  = rd_en ? shaped : '0;
         assign rvalid = rd_en;
      end
   endgenerate

endmodule

// File: rtl/crb_regctl.sv
module crb_regctl
   import crb_pkg::*;
#(
   parameter int         ADDR_W    = 16,
   parameter int         DATA_W    = 32,
   parameter int         LOC_LSB   = 12,
   parameter int         LOC_W     = 4,
   parameter logic [7:0] NO_LOC    = 8'hFF,
   parameter logic [1:0] XFER_CODE = 2'b11,
   parameter logic [7:0] REVISION  = 8'h00,
   parameter bit         RD_REG    = 1'b1
) (
   input  logic                            clk,
   input  logic                            rst_n,
   input  logic                            bus_sel,
   input  logic                            bus_wr,
   input  logic [ADDR_W-1:0]               bus_addr,
   input  logic [$clog2(DATA_W/8)-1:0]     bus_size,
   input  logic [DATA_W-1:0]               bus_wdata,
   output logic [DATA_W-1:0]               bus_rdata,
   output logic                            bus_rvalid,
   input  logic                            established_i,
   output logic                            issue_o,
   output logic                            cancel_o,
   input  logic                            done_i,
   input  logic                            done_err_i
);

   localparam int AL_W = 8;

   generate
      if (DATA_W != 32) begin : g_bad_width
         $error("crb_regctl: register layout needs DATA_W of 32");
      end
      if (LOC_LSB < OFS_W || LOC_LSB + LOC_W > ADDR_W) begin : g_bad_loc
         $error("crb_regctl: locality field must sit above the page offset");
      end
      if (LOC_W >= AL_W) begin : g_bad_locw
         $error("crb_regctl: locality field wider than active locality");
      end
   endgenerate

   crb_whit_t         whit;
   logic [DATA_W-1:0] wval;
   logic [DATA_W-1:0] lane_mask;
   logic [LOC_W-1:0]  page_loc;
   logic              rd_en;
   logic              loc_assigned;
   logic              loc_granted;
   logic              loc_seized;
   logic              idle_q;
   logic              fatal_q;
   logic              start_busy;
   logic [AL_W-1:0]   active_loc;

   crb_bus_dec #(
      .ADDR_W (ADDR_W),
      .DATA_W (DATA_W),
      .LOC_LSB(LOC_LSB),
      .LOC_W  (LOC_W)
   ) u_dec (
      .sel      (bus_sel),
      .wr       (bus_wr),
      .addr     (bus_addr),
      .size     (bus_size),
      .wdata    (bus_wdata),
      .whit     (whit),
      .wval     (wval),
      .lane_mask(lane_mask),
      .page_loc (page_loc),
      .rd_en    (rd_en)
   );

   crb_loc_ctl #(.DATA_W(DATA_W)) u_loc (
      .clk     (clk),
      .rst_n   (rst_n),
      .hit     (whit.lctrl),
      .wval    (wval),
      .assigned(loc_assigned),
      .granted (loc_granted),
      .seized  (loc_seized)
   );

   // only locality 0 can be granted, so the active field is zero when held
   assign active_loc = loc_assigned ? '0 : NO_LOC;

   crb_cmd_ctl #(
      .DATA_W(DATA_W),
      .LOC_W (LOC_W),
      .AL_W  (AL_W)
   ) u_cmd (
      .clk       (clk),
      .rst_n     (rst_n),
      .whit      (whit),
      .wval      (wval),
      .page_loc  (page_loc),
      .active_loc(active_loc),
      .done_i    (done_i),
      .done_err_i(done_err_i),
      .idle_q    (idle_q),
      .fatal_q   (fatal_q),
      .busy_q    (start_busy),
      .issue_q   (issue_o),
      .cancel_q  (cancel_o)
   );

   logic [DATA_W-1:0] w_lstate, w_lsts, w_ident, w_csts, w_start;

   always_comb begin
      w_lstate                             = '0;
      w_lstate[LS_EST]                     = ~established_i;
      w_lstate[LS_ASSIGN]                  = loc_assigned;
      w_lstate[LS_ACT_LSB +: LS_ACT_W]     = '0;
      w_lstate[LS_VALID]                   = 1'b1;

      w_lsts                               = '0;
      w_lsts[LT_GRANT]                     = loc_granted;
      w_lsts[LT_SEIZE]                     = loc_seized;

      w_ident                              = '0;
      w_ident[ID_TYPE_LSB +: 4]            = 4'd1;
      w_ident[ID_VER_LSB +: 4]             = 4'd1;
      w_ident[ID_CAPLOC]                   = 1'b0;
      w_ident[ID_IDLEBYP]                  = 1'b0;
      w_ident[ID_XFER_LSB +: 2]            = XFER_CODE;
      w_ident[ID_FIFO]                     = 1'b0;
      w_ident[ID_BUFIF]                    = 1'b1;
      w_ident[ID_SEL_LSB +: 2]             = 2'd1;
      w_ident[ID_REV_LSB +: 8]             = REVISION;

      w_csts                               = '0;
      w_csts[CS_FATAL]                     = fatal_q;
      w_csts[CS_IDLE]                      = idle_q;

      w_start                              = '0;
      w_start[0]                           = start_busy;
   end

   crb_rd_path #(
      .DATA_W(DATA_W),
      .RD_REG(RD_REG)
   ) u_rd (
      .clk      (clk),
      .rst_n    (rst_n),
      .rd_en    (rd_en),
      .ofs      (bus_addr[OFS_W-1:0]),
      .lane_mask(lane_mask),
      .w_lstate (w_lstate),
      .w_lsts   (w_lsts),
      .w_ident  (w_ident),
      .w_csts   (w_csts),
      .w_start  (w_start),
      .rdata    (bus_rdata),
      .rvalid   (bus_rvalid)
   );

endmodule

// File: rtl/crb_regctl_chk.sv
module crb_regctl_chk (
   input logic clk,
   input logic rst_n,
   input logic bus_sel,
   input logic bus_wr,
   input logic issue_o,
   input logic cancel_o,
   input logic done_i,
   input logic done_err_i,
   input logic start_busy,
   input logic fatal_q
);

   AST_ISSUE_FROM_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
      issue_o |-> $past(bus_sel && bus_wr)); // R4

   AST_ISSUE_MARKS_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
      issue_o |-> start_busy); // R4

   AST_ISSUE_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
      issue_o |=> !issue_o); // R4

   AST_NO_ISSUE_WHEN_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
      (start_busy && !done_i) |=> !issue_o); // R5

   AST_CANCEL_NEEDS_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
      cancel_o |-> $past(start_busy)); // R6

   AST_DONE_CLEARS_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
      (done_i && start_busy) |=> !start_busy); // R11

   AST_ERR_SETS_FATAL: assert property (@(posedge clk) disable iff (!rst_n)
      (done_i && done_err_i) |=> fatal_q); // R7

   AST_FATAL_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
      fatal_q |=> fatal_q); // R7

endmodule

bind crb_regctl crb_regctl_chk u_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .bus_sel   (bus_sel),
   .bus_wr    (bus_wr),
   .issue_o   (issue_o),
   .cancel_o  (cancel_o),
   .done_i    (done_i),
   .done_err_i(done_err_i),
   .start_busy(start_busy),
   .fatal_q   (fatal_q)
);

// File: tb/sim_crb_regctl.sv
`timescale 1ns/1ps
module sim_crb_regctl;

   localparam int HALF = 10;   // 50 MHz

   localparam logic [15:0] A_LSTATE = 16'h0000;
   localparam logic [15:0] A_LCTRL  = 16'h0004;
   localparam logic [15:0] A_LSTS   = 16'h0008;
   localparam logic [15:0] A_IDENT  = 16'h0010;
   localparam logic [15:0] A_CREQ   = 16'h0020;
   localparam logic [15:0] A_CSTS   = 16'h0024;
   localparam logic [15:0] A_CANCEL = 16'h0028;
   localparam logic [15:0] A_START  = 16'h002C;
   localparam logic [31:0] IDENT    = 32'h0002_5811;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        bus_sel = 1'b0;
   logic        bus_wr = 1'b0;
   logic [15:0] bus_addr = '0;
   logic [1:0]  bus_size = 2'd3;
   logic [31:0] bus_wdata = '0;
   logic [31:0] bus_rdata;
   logic        bus_rvalid;
   logic        established_i = 1'b1;
   logic        issue_o;
   logic        cancel_o;
   logic        done_i = 1'b0;
   logic        done_err_i = 1'b0;

   int n_tests = 0;
   int n_fail  = 0;
   int n_issue = 0;
   int n_cancel = 0;
   bit finished = 1'b0;

   logic [31:0] exp_q[$];
   string       tag_q[$];

   always #HALF clk = ~clk;

   crb_regctl u0 (
      .clk          (clk),
      .rst_n        (rst_n),
      .bus_sel      (bus_sel),
      .bus_wr       (bus_wr),
      .bus_addr     (bus_addr),
      .bus_size     (bus_size),
      .bus_wdata    (bus_wdata),
      .bus_rdata    (bus_rdata),
      .bus_rvalid   (bus_rvalid),
      .established_i(established_i),
      .issue_o      (issue_o),
      .cancel_o     (cancel_o),
      .done_i       (done_i),
      .done_err_i   (done_err_i)
   );

   task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
      n_tests++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s: actual 0x%08h expected 0x%08h", tag, act, exp);
      end
   endtask

   // scoreboard monitor: pops expected read data as the design returns it
   always @(negedge clk) begin
      if (issue_o)  n_issue++;
      if (cancel_o) n_cancel++;
      if (bus_rvalid) begin
         if (exp_q.size() == 0) begin
            n_tests++;
            n_fail++;
            $display("FAIL unexpected read data: actual 0x%08h expected none", bus_rdata);
         end else begin
            check(tag_q.pop_front(), bus_rdata, exp_q.pop_front());
         end
      end
   end

   task automatic wr(input logic [15:0] a, input logic [31:0] d, input logic [1:0] sz = 2'd3);
      @(negedge clk);
      bus_sel = 1'b1; bus_wr = 1'b1; bus_addr = a; bus_wdata = d; bus_size = sz;
      @(negedge clk);
      bus_sel = 1'b0; bus_wr = 1'b0;
   endtask

   // driver: queues the expected value, then issues the read
   task automatic rd(input logic [15:0] a, input logic [31:0] exp, input string tag,
                     input logic [1:0] sz = 2'd3);
      exp_q.push_back(exp);
      tag_q.push_back(tag);
      @(negedge clk);
      bus_sel = 1'b1; bus_wr = 1'b0; bus_addr = a; bus_size = sz;
      @(negedge clk);
      bus_sel = 1'b0;
   endtask

   task automatic complete(input logic err);
      @(negedge clk);
      done_i = 1'b1; done_err_i = err;
      @(negedge clk);
      done_i = 1'b0; done_err_i = 1'b0;
   endtask

   task automatic settle();
      @(negedge clk);
      #1;
   endtask

   initial begin : watchdog
      #(2 * HALF * 200000);
      if (!finished) begin
         n_tests++;
         n_fail++;
         $display("FAIL watchdog: actual timeout expected completion");
         $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
         $finish;
      end
   end

   initial begin : stim
      int base;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;

      // R1 reset values, R8 established inverse
      rd(A_LSTATE, 32'h80, "R1 lstate est=1");
      established_i = 1'b0;
      rd(A_LSTATE, 32'h81, "R8 lstate est=0");
      established_i = 1'b1;
      rd(A_CSTS,  32'h2,  "R1 csts");
      rd(A_IDENT, IDENT,  "R1 ident");
      rd(A_LSTS,  32'h0,  "R1 lsts");
      rd(A_START, 32'h0,  "R1 start");
      rd(16'h0100, 32'h0, "R10 undefined read");

      // R2 control request
      wr(A_CREQ, 32'd1);
      rd(A_CSTS, 32'h0, "R2 ready clears idle");
      wr(A_CREQ, 32'd3);
      rd(A_CSTS, 32'h0, "R2 code 3 ignored");
      wr(A_CREQ, 32'd2);
      rd(A_CSTS, 32'h2, "R2 idle sets idle");
      wr(A_CREQ, 32'd0);
      rd(A_CSTS, 32'h2, "R2 code 0 ignored");
      rd(A_CREQ, 32'h0, "R10 request reads zero");

      // R5 start before any locality is assigned
      base = n_issue;
      wr(A_START, 32'd1);
      settle();
      check("R5 start unassigned no pulse", 32'(n_issue - base), 32'd0);
      rd(A_START, 32'h0, "R5 start unassigned bit");

      // R3 locality control
      wr(A_LCTRL, 32'd8);
      rd(A_LSTATE, 32'h80, "R3 reset-establishment ignored");
      wr(A_LCTRL, 32'd1);
      rd(A_LSTATE, 32'h82, "R3 assigned set");
      rd(A_LSTS,   32'h1,  "R3 granted set");
      wr(A_LCTRL, 32'd3);
      rd(A_LSTATE, 32'h82, "R3 code 3 ignored");

      // R5 wrong page, wrong value
      base = n_issue;
      wr(16'h102C, 32'd1);
      wr(A_START, 32'd3);
      settle();
      check("R5 wrong page or value no pulse", 32'(n_issue - base), 32'd0);
      rd(A_START, 32'h0, "R5 start still clear");

      // R6 cancel with nothing pending
      base = n_cancel;
      wr(A_CANCEL, 32'd1);
      settle();
      check("R6 cancel idle no pulse", 32'(n_cancel - base), 32'd0);

      // R4 accepted start
      base = n_issue;
      wr(A_START, 32'd1);
      check("R4 issue pulse", {31'd0, issue_o}, 32'd1);
      settle();
      check("R4 one pulse", 32'(n_issue - base), 32'd1);
      rd(A_START, 32'h1, "R4 start bit set");
      rd(16'h102C, 32'h1, "R9 start mirrored in page 1");

      // R5 start while pending
      base = n_issue;
      wr(A_START, 32'd1);
      settle();
      check("R5 pending no pulse", 32'(n_issue - base), 32'd0);

      // R6 cancel values
      base = n_cancel;
      wr(A_CANCEL, 32'd2);
      settle();
      check("R6 cancel code 2 ignored", 32'(n_cancel - base), 32'd0);
      wr(A_CANCEL, 32'd1);
      settle();
      check("R6 cancel pulse", 32'(n_cancel - base), 32'd1);

      // R7 clean completion
      complete(1'b0);
      rd(A_START, 32'h0, "R7 done clears start");
      rd(A_CSTS,  32'h2, "R7 clean done no fatal");

      // R9 narrow reads and masked write
      rd(16'h0011, 32'h58,   "R9 byte read offset 1", 2'd0);
      rd(16'h0012, 32'h0002, "R9 half read offset 2", 2'd1);
      base = n_issue;
      wr(A_START, 32'h0000_0101, 2'd0);
      settle();
      check("R9 byte start accepted", 32'(n_issue - base), 32'd1);
      complete(1'b1);
      rd(A_CSTS,  32'h3, "R7 error sets fatal");
      rd(A_START, 32'h0, "R7 error done clears start");
      wr(16'h0021, 32'd1);
      rd(A_CSTS,  32'h3, "R9 unaligned write ignored");

      // R11 start write and completion in the same cycle
      wr(A_START, 32'd1);
      settle();
      base = n_issue;
      @(negedge clk);
      bus_sel = 1'b1; bus_wr = 1'b1; bus_addr = A_START; bus_wdata = 32'd1; bus_size = 2'd3;
      done_i = 1'b1; done_err_i = 1'b0;
      @(negedge clk);
      bus_sel = 1'b0; bus_wr = 1'b0; done_i = 1'b0;
      settle();
      check("R11 collision no pulse", 32'(n_issue - base), 32'd0);
      rd(A_START, 32'h0, "R11 start clear after collision");
      rd(A_CSTS,  32'h3, "R7 fatal sticky");
      wr(A_START, 32'd1);
      settle();
      check("R11 later start accepted", 32'(n_issue - base), 32'd1);
      complete(1'b0);

      // R10 writes to read-only and undefined offsets
      wr(A_IDENT,  32'h0);
      wr(A_LSTATE, 32'h0);
      wr(A_CSTS,   32'h0);
      wr(16'h0100, 32'hFFFF_FFFF);
      rd(A_IDENT,  IDENT,  "R10 ident unchanged");
      rd(A_LSTATE, 32'h82, "R10 lstate unchanged");
      rd(A_CSTS,   32'h3,  "R10 csts unchanged");
      rd(16'h0100, 32'h0,  "R10 undefined still zero");

      // R3 relinquish, then R5 start refused
      wr(A_LCTRL, 32'd2);
      rd(A_LSTATE, 32'h80, "R3 relinquish clears assigned");
      rd(A_LSTS,   32'h0,  "R3 relinquish clears granted");
      base = n_issue;
      wr(A_START, 32'd1);
      settle();
      check("R5 start after relinquish refused", 32'(n_issue - base), 32'd0);

      repeat (4) @(negedge clk);
      check("scoreboard drained", 32'(exp_q.size()), 32'd0);
      finished = 1'b1;
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
   end

endmodule